// File: doc/BRIEF.md
# Tap Position Register File with Deferred Non-Volatile Commit

This block is the register space that sits behind a two-wire serial slave and sets the position of a digitally controlled resistive tap. It holds a volatile 8-bit tap code that drives the resistor switch array. Address 0 also holds a non-volatile start-up value. Fourteen non-volatile general-purpose bytes and a control byte complete the space. The non-volatile cells are modelled as flops that keep their content across reset, so reset stands for a power cycle.

The serial front end presents decoded byte writes on a simple register port and gives a one-cycle pulse when it sees the bus STOP condition. A write to a non-volatile location is only captured when it arrives. The block commits it after STOP, in a self-timed cycle. While that cycle runs, a busy flag is readable in the control byte, and tap or control writes are refused. After reset, the tap code sits at mid-scale until a programmable delay has elapsed. It then takes the stored start-up value.

Top module: `wiper_regfile`

## Requirements
- R1: After reset `tap_code` is 80h and register writes are ignored for POR_CYCLES clock cycles. On the cycle that ends that window, `tap_code` loads the stored start-up value.
- R2: After the power-up window the control byte at address 10h reads 40h: select bit 7 = 0, enable bit 6 = 1, busy bit 5 = 0.
- R3: With control bit 7 = 1, a write to address 0 sets `tap_code` one cycle later and leaves the stored start-up value unchanged. A read of address 0 returns `tap_code`.
- R4: With control bit 7 = 0, a write to address 0 sets `tap_code` one cycle later and is committed to the start-up value. A read of address 0 returns the stored start-up value.
- R5: A non-volatile write (address 0 with bit 7 = 0, or addresses 01h–0Eh) changes nothing stored until a `stop` pulse follows it, however long the wait.
- R6: The cycle after a `stop` that follows a captured non-volatile write, control bit 5 reads 1. It stays 1 for exactly WC_CYCLES cycles. The stored byte reads its new value on the cycle bit 5 returns to 0.
- R7: While bit 5 is 1, writes to address 0 and 10h are refused, and any non-volatile write is dropped, so no later `stop` starts a cycle.
- R8: Only the first non-volatile write between two `stop` pulses is committed; later ones are dropped.
- R9: Control bits 4..0 always read 0. Writes to bits 5..0 have no effect.
- R10: `shutdown` is 1 exactly when control bit 6 is 0.
- R11: Address 0Fh and addresses above 10h read 00h, and writes to them change nothing.
- R12: Stored non-volatile bytes survive reset, and the next power-up recall loads the stored start-up value into `tap_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power cycle) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| stop | input | 1 | One-cycle pulse on bus STOP condition |
| rdata | output | 8 | Read data for `addr` (combinational) |
| tap_code | output | 8 | Tap position, 00h nearest low end, FFh nearest high end |
| shutdown | output | 1 | Open end-to-end path, wiper tied to low end |

## Verification
A capture latch that forgets, or commits too early, shows as a stored byte that reads back wrong, either before or just after the busy window. A busy counter that is off by one shows at the exact cycle bit 5 falls, so the bench samples both edges of the window. A wrong select bit or a leaked write lock shows on `tap_code` or `shutdown` one cycle after the offending write. A bad power-up sequence shows either as a mid-scale tap that never changes or as a recall value that differs from the last committed start-up byte.

// File: rtl/wrf_pkg.sv
`timescale 1ns/1ps
package wrf_pkg;
    localparam int DW        = 8;
    localparam int AW        = 5;
    localparam int NV_DEPTH  = 15;
    localparam int NV_AW     = 4;

    localparam logic [AW-1:0] ADDR_START   = 5'h00;
    localparam logic [AW-1:0] ADDR_GP_LAST = 5'h0E;
    localparam logic [AW-1:0] ADDR_CTRL    = 5'h10;

    localparam logic [DW-1:0] TAP_MID = 8'h80;
endpackage

// File: rtl/wrf_nv_store.sv
`timescale 1ns/1ps
module wrf_nv_store
    import wrf_pkg::*;
#(
    parameter int WC_CYCLES = 2400000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_i,
    input  logic [NV_AW-1:0]             req_addr_i,
    input  logic [DW-1:0]                req_data_i,
    input  logic                         stop_i,
    output logic                         pend_o,
    output logic                         wip_o,
    output logic [NV_DEPTH-1:0][DW-1:0]  mem_o
);
    localparam int CW = $clog2(WC_CYCLES + 1);

    typedef struct packed {
        logic             pend;
        logic [NV_AW-1:0] addr;
        logic [DW-1:0]    data;
        logic             wip;
        logic [CW-1:0]    cnt;
    } nv_st_t;

    nv_st_t st_d, st_q;
    logic   commit;
    logic [NV_DEPTH-1:0][DW-1:0] mem_q;

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        if (req_i && !st_q.pend && !st_q.wip) begin
            st_d.pend = 1'b1;
            st_d.addr = req_addr_i;
            st_d.data = req_data_i;
        end
        if (stop_i) begin
            if (st_q.pend && !st_q.wip) begin
                st_d.wip = 1'b1;
                st_d.cnt = CW'(WC_CYCLES - 1);
            end
            st_d.pend = 1'b0;
        end
        if (st_q.wip) begin
            if (st_q.cnt == '0) begin
                st_d.wip = 1'b0;
                commit   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Cell array: no reset, contents persist across power cycles
    always_ff @(posedge clk) begin
        for (int i = 0; i < NV_DEPTH; i++) begin
            if (commit && st_q.addr == NV_AW'(i)) begin
                mem_q[i] <= st_q.data;
            end
        end
    end

    assign pend_o = st_q.pend;
    assign wip_o  = st_q.wip;
    assign mem_o  = mem_q;

    assert_busy_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i && st_q.pend && !st_q.wip |=> wip_o);

    assert_busy_ends_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip_o) |-> $past(st_q.cnt) == '0);

    assert_store_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.wip && st_q.cnt == '0) |=> $stable(mem_q));

    assert_busy_drops_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wip_o && !stop_i |=> !pend_o);
endmodule

// File: rtl/wrf_ctrl.sv
`timescale 1ns/1ps
module wrf_ctrl
    import wrf_pkg::*;
#(
    parameter int POR_CYCLES = 1000000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [DW-1:0]  wdata_i,
    input  logic           wip_i,
    input  logic           pend_i,
    input  logic [DW-1:0]  start_val_i,
    output logic           nv_req_o,
    output logic [DW-1:0]  tap_o,
    output logic           vol_o,
    output logic           enable_o
);
    localparam int PCW = $clog2(POR_CYCLES + 1);

    typedef struct packed {
        logic           ready;
        logic [PCW-1:0] pcnt;
        logic [DW-1:0]  tap;
        logic           vol;
        logic           enable;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        nv_req_o = 1'b0;
        if (!st_q.ready) begin
            if (st_q.pcnt == '0) begin
                st_d.ready = 1'b1;
                st_d.tap   = start_val_i;
            end else begin
                st_d.pcnt = st_q.pcnt - 1'b1;
            end
        end else if (wr_en_i) begin
            if (addr_i == ADDR_START) begin
                if (st_q.vol) begin
                    if (!wip_i) st_d.tap = wdata_i;
                end else begin
                    nv_req_o = 1'b1;
                    if (!wip_i && !pend_i) st_d.tap = wdata_i;
                end
            end else if (addr_i <= ADDR_GP_LAST) begin
                nv_req_o = 1'b1;
            end else if (addr_i == ADDR_CTRL && !wip_i) begin
                st_d.vol    = wdata_i[7];
                st_d.enable = wdata_i[6];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ready  <= 1'b0;
            st_q.pcnt   <= PCW'(POR_CYCLES - 1);
            st_q.tap    <= TAP_MID;
            st_q.vol    <= 1'b0;
            st_q.enable <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tap_o    = st_q.tap;
    assign vol_o    = st_q.vol;
    assign enable_o = st_q.enable;

    assert_mid_during_powerup_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ready |-> tap_o == TAP_MID && vol_o == 1'b0 && enable_o == 1'b1);

    assert_recall_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ready) |-> tap_o == start_val_i);

    assert_busy_locks_regs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ready && wip_i |=> $stable(tap_o) && $stable(vol_o) && $stable(enable_o));

    assert_ctrl_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ready && wr_en_i && addr_i == ADDR_CTRL && !wip_i
        |=> enable_o == $past(wdata_i[6]) && vol_o == $past(wdata_i[7]));
endmodule

// File: rtl/wiper_regfile.sv
`timescale 1ns/1ps
module wiper_regfile
    import wrf_pkg::*;
#(
    parameter int WC_CYCLES  = 2400000,
    parameter int POR_CYCLES = 1000000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [4:0]  addr,
    input  logic [7:0]  wdata,
    input  logic        stop,
    output logic [7:0]  rdata,
    output logic [7:0]  tap_code,
    output logic        shutdown
);
    logic                        nv_req;
    logic                        nv_pend;
    logic                        nv_wip;
    logic [NV_DEPTH-1:0][DW-1:0] nv_mem;
    logic                        vol_sel;
    logic                        enable_bit;
    logic [DW-1:0]               tap_q;

    wrf_nv_store #(.WC_CYCLES(WC_CYCLES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (nv_req),
        .req_addr_i (addr[NV_AW-1:0]),
        .req_data_i (wdata),
        .stop_i     (stop),
        .pend_o     (nv_pend),
        .wip_o      (nv_wip),
        .mem_o      (nv_mem)
    );

    wrf_ctrl #(.POR_CYCLES(POR_CYCLES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .wip_i       (nv_wip),
        .pend_i      (nv_pend),
        .start_val_i (nv_mem[0]),
        .nv_req_o    (nv_req),
        .tap_o       (tap_q),
        .vol_o       (vol_sel),
        .enable_o    (enable_bit)
    );

    always_comb begin
        rdata = '0;
        if (addr == ADDR_START) begin
            rdata = vol_sel ? tap_q : nv_mem[0];
        end else if (addr == ADDR_CTRL) begin
            rdata = {vol_sel, enable_bit, nv_wip, 5'b00000};
        end else begin
            for (int i = 1; i < NV_DEPTH; i++) begin
                if (addr == AW'(i)) rdata = nv_mem[i];
            end
        end
    end

    assign tap_code = tap_q;
    assign shutdown = ~enable_bit;

    assert_ctrl_low_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        addr == ADDR_CTRL |-> rdata[4:0] == 5'b00000);
endmodule

// File: tb/tb_wiper_regfile.sv
`timescale 1ns/1ps
module tb_wiper_regfile;
    localparam int WC  = 40;
    localparam int POR = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       stop = 1'b0;
    logic [7:0] rdata;
    logic [7:0] tap_code;
    logic       shutdown;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] nv_m [0:14];
    logic [7:0] tap_m;
    logic       vol_m;
    logic       en_m;

    always #2.5 clk = ~clk;

    wiper_regfile #(.WC_CYCLES(WC), .POR_CYCLES(POR)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .stop(stop), .rdata(rdata), .tap_code(tap_code), .shutdown(shutdown)
    );

    function automatic logic [7:0] exp_read(input logic [4:0] a);
        if (a == 5'h00) return vol_m ? tap_m : nv_m[0];
        if (a >= 5'h01 && a <= 5'h0E) return nv_m[a[3:0]];
        if (a == 5'h10) return {vol_m, en_m, 6'b0};
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk);
        stop = 1'b1;
        @(posedge clk);
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [4:0] a, input logic [7:0] exp);
        addr = a;
        #0.5;
        chk(tag, rdata, exp);
    endtask

    task automatic nv_commit(input logic [4:0] a, input logic [7:0] d);
        wr(a, d);
        pulse_stop();
        repeat (WC) @(negedge clk);
        nv_m[a[3:0]] = d;
        if (a == 5'h00) tap_m = d;
    endtask

    task automatic power_up();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        vol_m = 1'b0; en_m = 1'b1;
    endtask

    initial begin
        logic [7:0] r;
        r = 8'($urandom(32'd2024));
        vol_m = 1'b0; en_m = 1'b1; tap_m = 8'h80;
        repeat (3) @(negedge clk);
        chk("R1 tap in reset", tap_code, 8'h80);
        rst_n = 1'b1;
        chk("R10 shutdown in reset", {7'b0, shutdown}, 8'h00);
        // write during power-up must be ignored
        wr(5'h10, 8'h00);
        chk("R1 tap mid during window", tap_code, 8'h80);
        repeat (POR + 2) @(negedge clk);
        rd("R2 control reset value", 5'h10, 8'h40);
        chk("R1 ignored ctrl write: shutdown", {7'b0, shutdown}, 8'h00);

        // fill all non-volatile bytes with known values
        for (int i = 0; i < 15; i++) nv_commit(5'(i), 8'(8'h30 + i));
        chk("R4 tap follows start value", tap_code, 8'h30);

        // R4 / R6: start value write, busy window edges
        wr(5'h00, 8'h5A);
        chk("R4 tap set before stop", tap_code, 8'h5A);
        rd("R5 start value before stop", 5'h00, 8'h30);
        pulse_stop();
        rd("R6 busy set after stop", 5'h10, 8'h60);
        repeat (WC - 1) @(negedge clk);
        rd("R6 busy still set at end", 5'h10, 8'h60);
        rd("R6 old value during busy", 5'h00, 8'h30);
        @(negedge clk);
        rd("R6 busy clear", 5'h10, 8'h40);
        rd("R4 start value committed", 5'h00, 8'h5A);
        nv_m[0] = 8'h5A; tap_m = 8'h5A;

        // R5: no stop, no commit
        wr(5'h03, 8'hC3);
        repeat (WC + 5) @(negedge clk);
        rd("R5 no commit without stop", 5'h03, nv_m[3]);
        pulse_stop();
        repeat (WC) @(negedge clk);
        nv_m[3] = 8'hC3;
        rd("R5 commit after stop", 5'h03, 8'hC3);

        // R8: second write in same transaction dropped
        wr(5'h04, 8'h44);
        wr(5'h05, 8'h55);
        wr(5'h00, 8'h99);
        chk("R8 tap not moved by dropped write", tap_code, 8'h5A);
        pulse_stop();
        repeat (WC) @(negedge clk);
        nv_m[4] = 8'h44;
        rd("R8 first write kept", 5'h04, 8'h44);
        rd("R8 second write dropped", 5'h05, nv_m[5]);
        rd("R8 start value kept", 5'h00, 8'h5A);

        // R7: writes refused during busy
        wr(5'h06, 8'h66);
        pulse_stop();
        wr(5'h10, 8'h80);
        wr(5'h00, 8'h12);
        wr(5'h07, 8'h77);
        chk("R7 tap locked", tap_code, 8'h5A);
        rd("R7 control locked", 5'h10, 8'h60);
        repeat (WC) @(negedge clk);
        nv_m[6] = 8'h66;
        pulse_stop();
        rd("R7 dropped request starts no cycle", 5'h10, 8'h40);
        rd("R7 dropped byte unchanged", 5'h07, nv_m[7]);

        // R9 / R10
        wr(5'h10, 8'h3F);
        rd("R9 low bits read zero", 5'h10, 8'h00);
        chk("R10 shutdown asserted", {7'b0, shutdown}, 8'h01);
        wr(5'h10, 8'h7F);
        rd("R9 enable only", 5'h10, 8'h40);
        chk("R10 shutdown released", {7'b0, shutdown}, 8'h00);

        // R3: volatile select
        wr(5'h10, 8'hC0); vol_m = 1'b1;
        wr(5'h00, 8'h77); tap_m = 8'h77;
        chk("R3 tap volatile write", tap_code, 8'h77);
        rd("R3 read returns tap", 5'h00, 8'h77);
        pulse_stop();
        rd("R3 no commit cycle", 5'h10, 8'hC0);
        wr(5'h10, 8'h40); vol_m = 1'b0;
        rd("R3 start value untouched", 5'h00, 8'h5A);

        // R11: reserved / unmapped
        wr(5'h0F, 8'hEE);
        wr(5'h11, 8'hEE);
        pulse_stop();
        rd("R11 reserved reads zero", 5'h0F, 8'h00);
        rd("R11 unmapped reads zero", 5'h1F, 8'h00);
        rd("R11 no busy", 5'h10, 8'h40);
        chk("R11 tap unchanged", tap_code, 8'h77);

        // random non-volatile traffic
        for (int k = 0; k < 20; k++) begin
            logic [4:0] a;
            logic [7:0] d;
            a = 5'(1 + ($urandom % 14));
            d = 8'($urandom);
            nv_commit(a, d);
            a = 5'($urandom % 15);
            rd("R5 random readback", a, exp_read(a));
        end

        // R12: power cycle keeps stored bytes and recalls start value
        power_up();
        tap_m = 8'h80;
        chk("R1 mid after power cycle", tap_code, 8'h80);
        repeat (POR + 2) @(negedge clk);
        tap_m = nv_m[0];
        chk("R12 recall start value", tap_code, nv_m[0]);
        for (int i = 1; i < 15; i++) rd("R12 byte retained", 5'(i), nv_m[i]);

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule